// File: doc/BRIEF.md
# Host Address Decoder with Remap

This block sits between the request sources of a host bridge and its targets. Every memory request carries a 39-bit address, a read/write flag and a source tag: the processor core, a legacy downstream port, or a graphics expansion port. The decoder checks the address against three fixed-size register windows, a graphics aperture with four tiling fences, a high-memory remap window, the usable low-DRAM region and an expansion-port window. From that it produces a target, a translated physical address, or a one-cycle abort. Anything that matches nothing goes to the legacy downstream port.

Configuration is loaded through a single-cycle write port that selects one register per write. Addresses above 4 GB that fall inside the remap window are translated onto the DRAM hidden under the hole above the low-DRAM top. DRAM is never claimed at or above a 32 GB ceiling. Graphics stolen memory and its translation table are carved from the top of low DRAM, so that range is not decoded as DRAM.

A request is accepted on `req_valid && req_ready`. Its result is registered and appears in the next cycle. A valid result is held until it is consumed.

Top module: `host_addr_router`

## Requirements
- R1: After reset every register window is disabled, the low-DRAM top and both carve-out size codes are 0, all fences are invalid, and the remap, aperture and expansion bases are all ones with limits of zero. Every accepted request then routes to the legacy port (target code 4) with its address unchanged.
- R2: `req_ready` is high when no result is pending or `rsp_ready` is high. A request accepted at one clock edge has its result on the outputs after that edge. While `rsp_valid` is high and `rsp_ready` is low, the target and address stay stable.
- R3: The register windows are checked first, in the order egress (select 0, 4 KB), controller (select 1, 32 KB), link (select 2, 4 KB). A window is enabled by bit 0 of its base and matches on the address bits above its size. A hit gives target 2 and returns the offset within the window.
- R4: A processor-core request (source 0) inside the aperture [base select 6, limit select 7] gives target 3 with the address unchanged, whatever the region type or direction. The aperture applies only when its limit is not below its base.
- R5: A request from source 1, 2 or 3 inside the aperture is rejected if it is a read, or if it is a write to a tiled region. A write to a linear region gives target 3. The tiling of an address comes from the lowest-numbered valid fence that contains it. Fence f uses base select 11+3f, limit select 12+3f, and control select 13+3f (bit 0 valid, bits 2:1 mode with 0 linear and any other value tiled). Where no fence matches, the region is linear.
- R6: A rejected request raises `rsp_abort` for exactly one cycle with `rsp_valid` low and target code 0, and produces no result.
- R7: An address at or above 4 GB inside the remap window [select 4, select 5] maps to DRAM (target 1) at address − remap base + low-DRAM top (select 3). A window whose limit is below its base is disabled.
- R8: DRAM is claimed only for a physical address below 32 GB. A remap result at or above 32 GB falls through to the later decode steps.
- R9: An address below (low-DRAM top − stolen size − table size) and below 32 GB goes to DRAM with the address unchanged. The carve-out and the hole up to 4 GB are not DRAM. The carve-out size is clamped at zero.
- R10: The sizes register (select 8) holds the stolen code in bits 2:0 and the table code in bits 5:4. Stolen code 0 means none; code c from 1 to 5 means 2^(24+c) bytes; codes 6 and 7 mean 512 MB. Table code 0, 1 and 2 or 3 mean 0, 1 MB and 2 MB.
- R11: An address in the expansion window [select 9, select 10], enabled when its limit is not below its base, gives target 5 with the address unchanged. This check follows low DRAM and comes before the legacy default.
- R12: The decode order is register windows, aperture, remap, low DRAM, expansion window, then legacy (target 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Register select |
| cfg_wdata | input | 39 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 39 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 2 | 0 core, 1 legacy port, 2 expansion port, 3 reserved (treated as external) |
| rsp_valid | output | 1 | Decode result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_target | output | 3 | 0 none, 1 DRAM, 2 register window, 3 graphics, 4 legacy, 5 expansion |
| rsp_addr | output | 39 | Translated physical address or window offset |
| rsp_abort | output | 1 | One-cycle reject pulse |

## Verification
The assertions check the handshake rules on every cycle:
- results are held while stalled;
- a new result or abort appears only after an accepted request;
- an abort never carries a valid result or a target;
- a DRAM result never reaches the 32 GB ceiling;
- a register-window result is always a small offset.

Only the bench's scenarios can show that the decode is correct. That covers the priority between overlapping regions, the fence lookup and per-source aperture rules, remap translation across the ceiling boundary, and the carve-out size encoding. The bench checks these against a reference model fed with directed corner cases and with seeded random addresses clustered around each region edge.

// File: rtl/hadr_pkg.sv
package hadr_pkg;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_DRAM   = 3'd1,
      TGT_REGS   = 3'd2,
      TGT_GFX    = 3'd3,
      TGT_LEGACY = 3'd4,
      TGT_EXPAN  = 3'd5
   } target_e;

   typedef enum logic [1:0] {
      SRC_CORE   = 2'd0,
      SRC_LEGACY = 2'd1,
      SRC_EXPAN  = 2'd2,
      SRC_RSVD   = 2'd3
   } src_e;

   localparam int NUM_WIN     = 3;
   localparam int SEL_LOW_TOP = 3;
   localparam int SEL_RM_BASE = 4;
   localparam int SEL_RM_LIM  = 5;
   localparam int SEL_AP_BASE = 6;
   localparam int SEL_AP_LIM  = 7;
   localparam int SEL_SIZES   = 8;
   localparam int SEL_EX_BASE = 9;
   localparam int SEL_EX_LIM  = 10;
   localparam int SEL_FENCE0  = 11;
   localparam int FENCE_REGS  = 3;

   // log2 of the span of register window w (egress, controller, link)
   function automatic int win_span_log2(input int w);
      case (w)
         1:       return 15;
         default: return 12;
      endcase
   endfunction

   function automatic logic [31:0] stolen_bytes(input logic [2:0] code);
      int sh;
      if (code == 3'd0) return 32'd0;
      sh = 24 + ((code > 3'd5) ? 5 : int'(code));
      return 32'd1 << sh;
   endfunction

   function automatic logic [31:0] table_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 32'd0;
         2'd1:    return 32'd1 << 20;
         default: return 32'd1 << 21;
      endcase
   endfunction

endpackage

// File: rtl/hadr_cfg_regs.sv
module hadr_cfg_regs
   import hadr_pkg::*;
#(
   parameter int AW        = 39,
   parameter int NUM_FENCE = 4,
   parameter int SELW      = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [SELW-1:0]                cfg_sel,
   input  logic [AW-1:0]                  cfg_wdata,
   output logic [NUM_WIN-1:0][AW-1:0]     win_base,
   output logic [AW-1:0]                  low_top,
   output logic [AW-1:0]                  rm_base,
   output logic [AW-1:0]                  rm_limit,
   output logic [AW-1:0]                  ap_base,
   output logic [AW-1:0]                  ap_limit,
   output logic [AW-1:0]                  ex_base,
   output logic [AW-1:0]                  ex_limit,
   output logic [2:0]                     stolen_code,
   output logic [1:0]                     table_code,
   output logic [NUM_FENCE-1:0][AW-1:0]   fen_base,
   output logic [NUM_FENCE-1:0][AW-1:0]   fen_limit,
   output logic [NUM_FENCE-1:0]           fen_valid,
   output logic [NUM_FENCE-1:0][1:0]      fen_mode
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_base    <= '0;
         low_top     <= '0;
         rm_base     <= '1;
         rm_limit    <= '0;
         ap_base     <= '1;
         ap_limit    <= '0;
         ex_base     <= '1;
         ex_limit    <= '0;
         stolen_code <= '0;
         table_code  <= '0;
      end else if (cfg_we) begin
         case (int'(cfg_sel))
            0, 1, 2:     win_base[cfg_sel[1:0]] <= cfg_wdata;
            SEL_LOW_TOP: low_top  <= cfg_wdata;
            SEL_RM_BASE: rm_base  <= cfg_wdata;
            SEL_RM_LIM:  rm_limit <= cfg_wdata;
            SEL_AP_BASE: ap_base  <= cfg_wdata;
            SEL_AP_LIM:  ap_limit <= cfg_wdata;
            SEL_SIZES: begin
               stolen_code <= cfg_wdata[2:0];
               table_code  <= cfg_wdata[5:4];
            end
            SEL_EX_BASE: ex_base  <= cfg_wdata;
            SEL_EX_LIM:  ex_limit <= cfg_wdata;
            default: ;
         endcase
      end
   end

   for (genvar f = 0; f < NUM_FENCE; f++) begin : g_fence_reg
      localparam int SEL_B = SEL_FENCE0 + FENCE_REGS * f;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fen_base[f]  <= '0;
            fen_limit[f] <= '0;
            fen_valid[f] <= 1'b0;
            fen_mode[f]  <= 2'd0;
         end else if (cfg_we) begin
            if (int'(cfg_sel) == SEL_B)     fen_base[f]  <= cfg_wdata;
            if (int'(cfg_sel) == SEL_B + 1) fen_limit[f] <= cfg_wdata;
            if (int'(cfg_sel) == SEL_B + 2) begin
               fen_valid[f] <= cfg_wdata[0];
               fen_mode[f]  <= cfg_wdata[2:1];
            end
         end
      end
   end

endmodule

// File: rtl/hadr_window_match.sv
module hadr_window_match #(
   parameter int AW        = 39,
   parameter int SPAN_LOG2 = 12
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   output logic          hit,
   output logic [AW-1:0] offset
);

   localparam logic [AW-1:0] OFF_MASK = (AW'(1) << SPAN_LOG2) - AW'(1);

   // bit 0 of the base doubles as the enable; it lies inside the offset field
   assign hit    = base[0] && ((addr & ~OFF_MASK) == (base & ~OFF_MASK));
   assign offset = addr & OFF_MASK;

endmodule

// File: rtl/hadr_fence_lookup.sv
module hadr_fence_lookup #(
   parameter int AW        = 39,
   parameter int NUM_FENCE = 4
) (
   input  logic [AW-1:0]                 addr,
   input  logic [NUM_FENCE-1:0][AW-1:0]  fen_base,
   input  logic [NUM_FENCE-1:0][AW-1:0]  fen_limit,
   input  logic [NUM_FENCE-1:0]          fen_valid,
   input  logic [NUM_FENCE-1:0][1:0]     fen_mode,
   output logic                          tiled
);

   logic [NUM_FENCE-1:0] fhit;

   for (genvar f = 0; f < NUM_FENCE; f++) begin : g_hit
      assign fhit[f] = fen_valid[f] && (addr >= fen_base[f]) && (addr <= fen_limit[f]);
   end

   // lowest index wins: scan from the top so the last write is the lowest hit
   always_comb begin
      tiled = 1'b0;
      for (int f = NUM_FENCE - 1; f >= 0; f--) begin
         if (fhit[f]) tiled = (fen_mode[f] != 2'd0);
      end
   end

endmodule

// File: rtl/hadr_route.sv
module hadr_route
   import hadr_pkg::*;
#(
   parameter int AW        = 39,
   parameter int CEIL_BITS = 35
) (
   input  logic [AW-1:0] addr,
   input  logic          is_write,
   input  src_e          src,
   input  logic          win_any,
   input  logic [AW-1:0] win_offset,
   input  logic [AW-1:0] low_top,
   input  logic [AW-1:0] rm_base,
   input  logic [AW-1:0] rm_limit,
   input  logic [AW-1:0] ap_base,
   input  logic [AW-1:0] ap_limit,
   input  logic [AW-1:0] ex_base,
   input  logic [AW-1:0] ex_limit,
   input  logic [2:0]    stolen_code,
   input  logic [1:0]    table_code,
   input  logic          fence_tiled,
   output target_e       target,
   output logic [AW-1:0] phys,
   output logic          reject
);

   localparam logic [AW-1:0] FOUR_GB = AW'(1) << 32;
   localparam logic [AW:0]   CEIL    = (AW + 1)'(1) << CEIL_BITS;

   logic          ap_hit, rm_hit, rm_below_ceil, low_hit, ex_hit, external;
   logic [AW:0]   rm_phys;
   logic [AW-1:0] carve, usable;

   assign external = (src != SRC_CORE);

   assign ap_hit = (ap_limit >= ap_base) && (addr >= ap_base) && (addr <= ap_limit);

   assign rm_hit = (rm_limit >= rm_base) && (addr >= FOUR_GB) &&
                   (addr >= rm_base) && (addr <= rm_limit);
   assign rm_phys       = {1'b0, addr} - {1'b0, rm_base} + {1'b0, low_top};
   assign rm_below_ceil = rm_phys < CEIL;

   assign carve  = AW'(stolen_bytes(stolen_code)) + AW'(table_bytes(table_code));
   assign usable = (low_top >= carve) ? (low_top - carve) : '0;
   assign low_hit = (addr < usable) && ({1'b0, addr} < CEIL);

   assign ex_hit = (ex_limit >= ex_base) && (addr >= ex_base) && (addr <= ex_limit);

   always_comb begin
      target = TGT_LEGACY;
      phys   = addr;
      reject = 1'b0;
      if (win_any) begin
         target = TGT_REGS;
         phys   = win_offset;
      end else if (ap_hit) begin
         if (external && (!is_write || fence_tiled)) begin
            target = TGT_NONE;
            phys   = '0;
            reject = 1'b1;
         end else begin
            target = TGT_GFX;
         end
      end else if (rm_hit && rm_below_ceil) begin
         target = TGT_DRAM;
         phys   = rm_phys[AW-1:0];
      end else if (low_hit) begin
         target = TGT_DRAM;
      end else if (ex_hit) begin
         target = TGT_EXPAN;
      end
   end

endmodule

// File: rtl/host_addr_router.sv
module host_addr_router
   import hadr_pkg::*;
#(
   parameter int  AW        = 39,
   parameter int  NUM_FENCE = 4,
   parameter int  CEIL_BITS = 35,
   localparam int SELW      = $clog2(SEL_FENCE0 + FENCE_REGS * NUM_FENCE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [SELW-1:0] cfg_sel,
   input  logic [AW-1:0]   cfg_wdata,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_write,
   input  logic [1:0]      req_src,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [2:0]      rsp_target,
   output logic [AW-1:0]   rsp_addr,
   output logic            rsp_abort
);

   if (AW < 33) begin : g_bad_aw
      $error("host_addr_router: AW must reach above 4 GB");
   end
   if (CEIL_BITS >= AW || CEIL_BITS < 32) begin : g_bad_ceil
      $error("host_addr_router: CEIL_BITS must lie in [32, AW)");
   end
   if (NUM_FENCE < 1) begin : g_bad_fence
      $error("host_addr_router: at least one fence required");
   end

   logic [NUM_WIN-1:0][AW-1:0]   win_base;
   logic [AW-1:0]                low_top, rm_base, rm_limit, ap_base, ap_limit, ex_base, ex_limit;
   logic [2:0]                   stolen_code;
   logic [1:0]                   table_code;
   logic [NUM_FENCE-1:0][AW-1:0] fen_base, fen_limit;
   logic [NUM_FENCE-1:0]         fen_valid;
   logic [NUM_FENCE-1:0][1:0]    fen_mode;

   hadr_cfg_regs #(.AW(AW), .NUM_FENCE(NUM_FENCE), .SELW(SELW)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .win_base(win_base), .low_top(low_top), .rm_base(rm_base), .rm_limit(rm_limit),
      .ap_base(ap_base), .ap_limit(ap_limit), .ex_base(ex_base), .ex_limit(ex_limit),
      .stolen_code(stolen_code), .table_code(table_code),
      .fen_base(fen_base), .fen_limit(fen_limit), .fen_valid(fen_valid), .fen_mode(fen_mode)
   );

   logic [NUM_WIN-1:0]          win_hit;
   logic [NUM_WIN-1:0][AW-1:0]  win_offs;
   logic                        win_any;
   logic [AW-1:0]               win_off;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      hadr_window_match #(.AW(AW), .SPAN_LOG2(win_span_log2(w))) match_i (
         .addr(req_addr), .base(win_base[w]), .hit(win_hit[w]), .offset(win_offs[w])
      );
   end

   always_comb begin
      win_any = 1'b0;
      win_off = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (win_hit[w]) begin
            win_any = 1'b1;
            win_off = win_offs[w];
         end
      end
   end

   logic fence_tiled;

   hadr_fence_lookup #(.AW(AW), .NUM_FENCE(NUM_FENCE)) fence_i (
      .addr(req_addr), .fen_base(fen_base), .fen_limit(fen_limit),
      .fen_valid(fen_valid), .fen_mode(fen_mode), .tiled(fence_tiled)
   );

   target_e       dec_target;
   logic [AW-1:0] dec_phys;
   logic          dec_reject;

   hadr_route #(.AW(AW), .CEIL_BITS(CEIL_BITS)) route_i (
      .addr(req_addr), .is_write(req_write), .src(src_e'(req_src)),
      .win_any(win_any), .win_offset(win_off),
      .low_top(low_top), .rm_base(rm_base), .rm_limit(rm_limit),
      .ap_base(ap_base), .ap_limit(ap_limit), .ex_base(ex_base), .ex_limit(ex_limit),
      .stolen_code(stolen_code), .table_code(table_code), .fence_tiled(fence_tiled),
      .target(dec_target), .phys(dec_phys), .reject(dec_reject)
   );

   logic    accept;
   target_e tgt_q;

   assign req_ready  = !rsp_valid || rsp_ready;
   assign accept     = req_valid && req_ready;
   assign rsp_target = tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_abort <= 1'b0;
         tgt_q     <= TGT_NONE;
         rsp_addr  <= '0;
      end else begin
         rsp_abort <= accept && dec_reject;
         if (accept) begin
            rsp_valid <= !dec_reject;
            tgt_q     <= dec_reject ? TGT_NONE : dec_target;
            rsp_addr  <= dec_reject ? '0 : dec_phys;
         end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/hadr_checker.sv
module hadr_checker #(
   parameter int AW        = 39,
   parameter int CEIL_BITS = 35
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          rsp_ready,
   input logic [2:0]    rsp_target,
   input logic [AW-1:0] rsp_addr,
   input logic          rsp_abort
);

   localparam logic [AW:0] CEIL = (AW + 1)'(1) << CEIL_BITS;

   assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_target) && $stable(rsp_addr)));

   assert_result_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rsp_valid) || $rose(rsp_abort)) |-> $past(req_valid && req_ready));

   assert_abort_no_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_abort |-> (!rsp_valid && rsp_target == 3'd0));

   assert_valid_has_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_target != 3'd0));

   assert_dram_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == 3'd1) |-> ({1'b0, rsp_addr} < CEIL));

   assert_reg_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == 3'd2) |-> (rsp_addr < (AW'(1) << 15)));

endmodule

bind host_addr_router hadr_checker #(.AW(AW), .CEIL_BITS(CEIL_BITS)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
   .rsp_addr(rsp_addr), .rsp_abort(rsp_abort)
);

// File: tb/host_addr_router_tb_top.sv
`timescale 1ns/1ps
module host_addr_router_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_sel = '0;
   logic [38:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [38:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_src = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [2:0]  rsp_target;
   logic [38:0] rsp_addr;
   logic        rsp_abort;

   always #5 clk = ~clk;

   host_addr_router dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_src(req_src), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
      .rsp_abort(rsp_abort)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [38:0] sh [0:22];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input int sel, input logic [38:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 5'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      sh[sel] = d;
   endtask

   // reference decode written from the requirements
   function automatic void model(input logic [38:0] a, input bit wr, input logic [1:0] s,
                                 output logic [2:0] t, output logic [38:0] p, output bit ab);
      logic [39:0] rp;
      logic [38:0] sb, tb, carve, usable;
      logic [2:0]  c;
      bit tiled, dn;
      ab = 0; t = 3'd4; p = a; dn = 0;
      if (sh[0][0] && a[38:12] == sh[0][38:12]) begin t = 3'd2; p = {27'd0, a[11:0]}; dn = 1; end
      else if (sh[1][0] && a[38:15] == sh[1][38:15]) begin t = 3'd2; p = {24'd0, a[14:0]}; dn = 1; end
      else if (sh[2][0] && a[38:12] == sh[2][38:12]) begin t = 3'd2; p = {27'd0, a[11:0]}; dn = 1; end
      if (!dn && sh[7] >= sh[6] && a >= sh[6] && a <= sh[7]) begin
         dn = 1; tiled = 0;
         for (int f = 3; f >= 0; f--)
            if (sh[13+3*f][0] && a >= sh[11+3*f] && a <= sh[12+3*f]) tiled = (sh[13+3*f][2:1] != 2'd0);
         if (s != 2'd0 && (!wr || tiled)) begin ab = 1; t = 3'd0; p = '0; end
         else begin t = 3'd3; p = a; end
      end
      if (!dn && sh[5] >= sh[4] && a >= 39'h1_0000_0000 && a >= sh[4] && a <= sh[5]) begin
         rp = {1'b0, a} - {1'b0, sh[4]} + {1'b0, sh[3]};
         if (rp < 40'h8_0000_0000) begin t = 3'd1; p = rp[38:0]; dn = 1; end
      end
      c  = sh[8][2:0];
      sb = (c == 3'd0) ? 39'd0 : (39'd1 << (24 + ((c > 3'd5) ? 5 : int'(c))));
      tb = (sh[8][5:4] == 2'd0) ? 39'd0 : (sh[8][5:4] == 2'd1) ? 39'h10_0000 : 39'h20_0000;
      carve  = sb + tb;
      usable = (sh[3] >= carve) ? sh[3] - carve : 39'd0;
      if (!dn && a < usable && a < 39'h8_0000_0000) begin t = 3'd1; p = a; dn = 1; end
      if (!dn && sh[10] >= sh[9] && a >= sh[9] && a <= sh[10]) t = 3'd5;
   endfunction

   task automatic send(input string req, input logic [38:0] a, input bit wr, input logic [1:0] s);
      logic [2:0]  et;
      logic [38:0] ep;
      bit eab;
      model(a, wr, s, et, ep, eab);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_src = s;
      @(negedge clk);
      req_valid = 1'b0;
      if (eab) begin
         chk({req, " abort"}, 64'(rsp_abort), 64'd1);
         chk({req, " valid"}, 64'(rsp_valid), 64'd0);
         chk({req, " target"}, 64'(rsp_target), 64'd0);
      end else begin
         chk({req, " valid"}, 64'(rsp_valid), 64'd1);
         chk({req, " abort"}, 64'(rsp_abort), 64'd0);
         chk({req, " target"}, 64'(rsp_target), 64'(et));
         chk({req, " addr"}, 64'(rsp_addr), 64'(ep));
      end
   endtask

   function automatic logic [38:0] pick_addr();
      logic [38:0] anchor;
      case ($urandom % 12)
         0:  anchor = 39'h0_FED1_0000;
         1:  anchor = 39'h0_FED1_8000;
         2:  anchor = 39'h0_FED4_0000;
         3:  anchor = 39'h0_C000_0000;
         4:  anchor = 39'h0_C180_0000;
         5:  anchor = 39'h0_C300_0000;
         6:  anchor = 39'h0_7BF0_0000;
         7:  anchor = 39'h1_0000_0000;
         8:  anchor = 39'h1_8000_0000;
         9:  anchor = 39'h20_0000_0000;
         10: anchor = 39'h0_C500_0000;
         default: return 39'({$urandom, $urandom});
      endcase
      return anchor + 39'($urandom % 32'h2_0000) - 39'h1_0000;
   endfunction

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired before the test completed");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [38:0] seed_sink;
      for (int i = 0; i < 23; i++) sh[i] = '0;
      sh[4] = '1; sh[6] = '1; sh[9] = '1;
      seed_sink = 39'($urandom(32'h5EED_1234));

      repeat (3) @(negedge clk);
      chk("R1 reset valid", 64'(rsp_valid), 64'd0);
      chk("R1 reset abort", 64'(rsp_abort), 64'd0);
      chk("R2 reset ready", 64'(req_ready), 64'd1);
      rst_n = 1'b1;

      send("R1 low addr to legacy", 39'h0000_1000, 1'b0, 2'd0);
      send("R1 high addr to legacy", 39'h1_2345_6780, 1'b1, 2'd1);
      send("R1 aperture-area addr to legacy", 39'h0_C000_0000, 1'b0, 2'd2);

      cfg(0, 39'h0_FED1_0001);
      cfg(1, 39'h0_FED1_8001);
      cfg(2, 39'h0_FED4_0001);
      cfg(3, 39'h0_8000_0000);
      cfg(8, 39'h12);                  // stolen code 2 (64 MB), table code 1 (1 MB)
      cfg(6, 39'h0_C000_0000);
      cfg(7, 39'h0_CFFF_FFFF);
      cfg(11, 39'h0_C100_0000); cfg(12, 39'h0_C1FF_FFFF); cfg(13, 39'h3);  // X
      cfg(14, 39'h0_C180_0000); cfg(15, 39'h0_C2FF_FFFF); cfg(16, 39'h1);  // linear
      cfg(17, 39'h0_C300_0000); cfg(18, 39'h0_C3FF_FFFF); cfg(19, 39'h5);  // Y
      cfg(20, 39'h0_C400_0000); cfg(21, 39'h0_C4FF_FFFF); cfg(22, 39'h4);  // invalid
      cfg(4, 39'h1_0000_0000);
      cfg(5, 39'h1_7FFF_FFFF);
      cfg(9, 39'h20_0000_0000);
      cfg(10, 39'h20_FFFF_FFFF);

      send("R3 egress window offset", 39'h0_FED1_0ABC, 1'b0, 2'd0);
      send("R3 controller window top", 39'h0_FED1_FFFF, 1'b1, 2'd1);
      send("R3 link window", 39'h0_FED4_0010, 1'b0, 2'd2);
      send("R3 just past egress", 39'h0_FED1_1000, 1'b0, 2'd0);
      send("R4 core read tiled", 39'h0_C100_0040, 1'b0, 2'd0);
      send("R4 core write Y", 39'h0_C300_0040, 1'b1, 2'd0);
      send("R5 external write linear", 39'h0_C200_0000, 1'b1, 2'd1);
      send("R5 external read rejected", 39'h0_C200_0000, 1'b0, 2'd2);
      send("R5 overlap lowest fence X", 39'h0_C190_0000, 1'b1, 2'd2);
      send("R5 write Y rejected", 39'h0_C300_1000, 1'b1, 2'd1);
      send("R5 invalid fence is linear", 39'h0_C400_1000, 1'b1, 2'd3);
      send("R5 no fence is linear", 39'h0_C800_0000, 1'b1, 2'd2);

      @(negedge clk);
      chk("R6 abort lasts one cycle", 64'(rsp_abort), 64'd0);
      chk("R6 no result after abort", 64'(rsp_valid), 64'd0);

      send("R7 remap base", 39'h1_0000_0000, 1'b0, 2'd0);
      send("R7 remap limit", 39'h1_7FFF_FFFF, 1'b1, 2'd0);
      send("R7 past remap limit", 39'h1_8000_0000, 1'b0, 2'd0);
      send("R9 last usable low", 39'h0_7BEF_FFFF, 1'b0, 2'd0);
      send("R9 first carve-out byte", 39'h0_7BF0_0000, 1'b0, 2'd0);
      send("R9 hole below 4GB", 39'h0_9000_0000, 1'b1, 2'd1);
      send("R11 expansion window", 39'h20_0000_0100, 1'b1, 2'd0);
      send("R11 past expansion window", 39'h21_0000_0000, 1'b1, 2'd0);

      // R2 stall: result must hold while rsp_ready is low
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_addr = 39'h0000_0100; req_write = 1'b0; req_src = 2'd0;
      @(negedge clk);
      chk("R2 result after one cycle", 64'(rsp_valid), 64'd1);
      chk("R2 ready low while stalled", 64'(req_ready), 64'd0);
      req_addr = 39'h0_FED1_0004;
      @(negedge clk);
      chk("R2 target held", 64'(rsp_target), 64'd1);
      chk("R2 addr held", 64'(rsp_addr), 64'h100);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 next result target", 64'(rsp_target), 64'd2);
      chk("R2 next result addr", 64'(rsp_addr), 64'h4);
      @(negedge clk);
      chk("R2 valid drops when consumed", 64'(rsp_valid), 64'd0);

      for (int i = 0; i < 600; i++) begin
         send("R12 random decode", pick_addr(), 1'($urandom), 2'($urandom));
      end

      // R8 ceiling and R7 disable
      cfg(4, 39'h10_0000_0000);
      cfg(5, 39'h7F_FFFF_FFFF);
      send("R8 below ceiling", 39'h17_7FFF_FFFF, 1'b0, 2'd0);
      send("R8 at ceiling not DRAM", 39'h17_8000_0000, 1'b0, 2'd0);
      send("R8 ceiling falls to expansion", 39'h20_0000_0000, 1'b1, 2'd0);
      cfg(4, 39'h2_0000_0000);
      cfg(5, 39'h1_0000_0000);
      send("R7 inverted window disabled", 39'h1_8000_0000, 1'b0, 2'd0);

      // R10 size encodings
      cfg(8, 39'h37);                  // stolen 7 -> 512 MB, table 3 -> 2 MB
      send("R10 clamp last usable", 39'h0_5FDF_FFFF, 1'b0, 2'd0);
      send("R10 clamp carve start", 39'h0_5FE0_0000, 1'b0, 2'd0);
      cfg(8, 39'h25);                  // stolen 5 -> 512 MB, table 2 -> 2 MB
      send("R10 code5 carve start", 39'h0_5FE0_0000, 1'b0, 2'd0);
      cfg(8, 39'h00);
      send("R10 no carve top byte", 39'h0_7FFF_FFFF, 1'b0, 2'd0);
      cfg(3, 39'h0_0010_0000);
      cfg(8, 39'h01);                  // carve larger than top: nothing usable
      send("R9 carve clamps to zero", 39'h0000_0000, 1'b0, 2'd0);

      // R12 priority: register window inside aperture
      cfg(0, 39'h0_C000_0001);
      send("R12 window beats aperture", 39'h0_C000_0010, 1'b0, 2'd1);

      for (int i = 0; i < 300; i++) begin
         send("R12 random decode", pick_addr(), 1'($urandom), 2'($urandom));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule